// File: doc/BRIEF.md
# Secondary Bus Request/Grant Arbiter with External Bypass

This block decides which master owns a bridge's secondary bus. Five masters compete for it: four outside agents, each with an active-low request/grant pair numbered 0 to 3, and the bridge itself. In internal mode the block grants the bus in round-robin order. A grant stays with its owner while a transaction is running. When nobody asks for the bus, the grant is parked on the bridge.

A static strap selects external mode. In that mode the internal arbiter is switched off and pair 0 changes its role. Request input 0 becomes the grant that an outside arbiter gives to the bridge, and grant output 0 carries the bridge's own request out to that arbiter. Grant outputs 1 to 3 lose their output enables, so a top level can model those pins as floating. Request inputs 1 to 3 are then ignored.

Top module: `sec_bus_arb`

## Requirements
- R1: While `rst` is high at a rising edge, every internal-mode grant output (`gnt_n[3:0]` and `br_gnt_n`) reads 1 after that edge.
- R2: In internal mode (`ext_mode`=0), `gnt_oe` is 4'b1111.
- R3: In internal mode, at most one of the five grants (`gnt_n[0..3]`, `br_gnt_n`) is low at any time.
- R4: When the grant may move, the new owner is the first requester found after the previous owner, in the cyclic order 0,1,2,3,bridge. After reset, the search starts at pair 0. The bridge requests with `br_req_n`=0.
- R5: While the bus is busy (`frame_n`=0 or `irdy_n`=0) and the current owner keeps its request low, the grant stays with that owner.
- R6: When the grant may move and no master requests, the grant goes to the bridge (`br_gnt_n`=0).
- R7: In external mode, `br_gnt_n` equals `req_n[0]` in the same cycle.
- R8: In external mode, `gnt_n[0]` equals `br_req_n` in the same cycle, and `gnt_oe[0]`=1.
- R9: In external mode, `gnt_oe[3:1]` is 3'b000 and `gnt_n[3:1]` holds the value 3'b111.
- R10: In external mode, `req_n[3:1]` have no effect on any output.
- R11: In internal mode, grants are registered. A request sampled at a rising edge can change the grants only after that edge, never in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything is sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ext_mode | input | 1 | Static strap: 1 selects an outside arbiter |
| req_n | input | NPAIR | Active-low requests from the outside masters; in external mode bit 0 is the bridge's grant |
| br_req_n | input | 1 | Active-low bus request from the bridge core |
| frame_n | input | 1 | Active-low frame signal of the secondary bus |
| irdy_n | input | 1 | Active-low initiator-ready signal of the secondary bus |
| gnt_n | output | NPAIR | Active-low grants to the outside masters; in external mode bit 0 is the bridge's request |
| gnt_oe | output | NPAIR | Output enable for each `gnt_n` pin |
| br_gnt_n | output | 1 | Active-low grant to the bridge core |

## Verification
The assertions assume that the `ext_mode` strap does not change while the block is out of reset. They also assume that `frame_n` and `irdy_n` come from a bus whose owner holds its request for as long as it keeps the bus busy. The stimulus ties the strap to a constant on each of two instances, one internal and one external, and drives every input on the falling edge. The bus-busy and request patterns come from a pseudo-random sequence plus a sweep over all 32 request combinations. Those patterns include cases where the owner drops its request in the middle of a busy bus, which the design treats as a release.

// File: rtl/sec_bus_arb.sv
module sec_bus_arb #(
  parameter int NPAIR = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_mode,
  input  logic [NPAIR-1:0] req_n,
  input  logic             br_req_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  output logic [NPAIR-1:0] gnt_n,
  output logic [NPAIR-1:0] gnt_oe,
  output logic             br_gnt_n
);
  localparam int M = NPAIR + 1;
  localparam int W = $clog2(M + 1);
  localparam logic [W-1:0] BRIDGE = W'(NPAIR);
  localparam logic [W-1:0] NONE = '1;

  logic [W-1:0] own, nxt, base;
  logic [M-1:0] reqv;
  logic         cur_req, may_move;

  assign reqv     = {~br_req_n, ~req_n};
  assign base     = (own < W'(M)) ? own : BRIDGE;
  assign cur_req  = (own < W'(M)) ? reqv[own] : 1'b0;
  assign may_move = (frame_n && irdy_n) || !cur_req;

  always_comb begin
    logic found;
    logic [W:0] idx;
    nxt   = BRIDGE;
    found = 1'b0;
    for (int k = 1; k <= M; k++) begin
      idx = {1'b0, base} + (W+1)'(k);
      if (idx >= (W+1)'(M)) idx = idx - (W+1)'(M);
      if (!found && reqv[idx[W-1:0]]) begin
        nxt   = idx[W-1:0];
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ext_mode) own <= NONE;
    else if (may_move)   own <= nxt;
  end

  generate
    for (genvar i = 0; i < NPAIR; i++) begin : g_pin
      if (i == 0) begin : g_swap
        assign gnt_n[i]  = ext_mode ? br_req_n : (own != W'(i));
        assign gnt_oe[i] = 1'b1;
      end else begin : g_plain
        assign gnt_n[i]  = ext_mode ? 1'b1 : (own != W'(i));
        assign gnt_oe[i] = !ext_mode;
      end

      // R5
      assert property (@(posedge clk) disable iff (rst || ext_mode)
        (!gnt_n[i] && !req_n[i] && (!frame_n || !irdy_n)) |=> !gnt_n[i])
        else $error("grant_hold_chk pair %0d", i);
    end
  endgenerate

  assign br_gnt_n = ext_mode ? req_n[0] : (own != BRIDGE);

  // R3
  one_grant_chk: assert property (@(posedge clk) disable iff (rst || ext_mode)
    $onehot0(~{br_gnt_n, gnt_n}));

  // R5
  bridge_hold_chk: assert property (@(posedge clk) disable iff (rst || ext_mode)
    (!br_gnt_n && !br_req_n && (!frame_n || !irdy_n)) |=> !br_gnt_n);

  // R6
  park_chk: assert property (@(posedge clk) disable iff (rst || ext_mode)
    (frame_n && irdy_n && (&req_n) && br_req_n) |=> !br_gnt_n);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    (rst && !ext_mode) |=> ((&gnt_n) && br_gnt_n));
endmodule

// File: tb/sim_sec_bus_arb.sv
`timescale 1ns/1ps
module sim_sec_bus_arb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  logic [3:0] req_n = 4'hF;
  logic       br_req_n = 1'b1, frame_n = 1'b1, irdy_n = 1'b1;
  logic [3:0] g0_n, oe0, g1_n, oe1;
  logic       bg0_n, bg1_n;

  sec_bus_arb #(.NPAIR(4)) u0 (.clk(clk), .rst(rst), .ext_mode(1'b0), .req_n(req_n),
    .br_req_n(br_req_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .gnt_n(g0_n), .gnt_oe(oe0), .br_gnt_n(bg0_n));
  sec_bus_arb #(.NPAIR(4)) u1 (.clk(clk), .rst(rst), .ext_mode(1'b1), .req_n(req_n),
    .br_req_n(br_req_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .gnt_n(g1_n), .gnt_oe(oe1), .br_gnt_n(bg1_n));

  int nchk = 0, nfail = 0;
  int m_own = 7;
  string m_tag = "R1";
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) begin
    logic [4:0] rv;
    bit mv, found;
    int base, idx, pick;
    rv = {~br_req_n, ~req_n};
    if (rst) begin
      m_own = 7; m_tag = "R1";
    end else begin
      mv = (frame_n && irdy_n) || m_own == 7 || !rv[m_own];
      if (!mv) m_tag = "R5";
      else begin
        base = (m_own == 7) ? 4 : m_own;
        found = 0; pick = 4;
        for (int k = 1; k <= 5; k++) begin
          idx = (base + k) % 5;
          if (!found && rv[idx]) begin pick = idx; found = 1; end
        end
        m_own = pick;
        m_tag = found ? "R4" : "R6";
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [3:0] eg;
    logic eb;
    eg = 4'hF;
    for (int i = 0; i < 4; i++) if (m_own == i) eg[i] = 1'b0;
    eb = !(m_own == 4);
    chk(g0_n == eg, m_tag, g0_n, eg);
    chk(bg0_n == eb, m_tag, bg0_n, eb);
    chk($countones(~{bg0_n, g0_n}) <= 1, "R3", {bg0_n, g0_n}, 0);
    chk(oe0 == 4'hF, "R2", oe0, 4'hF);
    chk(bg1_n == req_n[0], "R7", bg1_n, req_n[0]);
    chk(g1_n[0] == br_req_n && oe1[0], "R8", {oe1[0], g1_n[0]}, {1'b1, br_req_n});
    chk(oe1[3:1] == 3'b000 && g1_n[3:1] == 3'b111, "R9", {oe1[3:1], g1_n[3:1]}, 6'b000111);
    chk(g1_n == {3'b111, br_req_n} && bg1_n == req_n[0], "R10",
        {bg1_n, g1_n}, {req_n[0], 3'b111, br_req_n});
  endtask

  task automatic step();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  bit done = 0;
  initial begin
    #(4 * 200000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all();
    rst = 1'b0; req_n = 4'b1011;
    #0.5;
    chk(g0_n == 4'hF && bg0_n, "R11", {bg0_n, g0_n}, 5'h1F);
    @(negedge clk);
    check_all();
    chk(g0_n == 4'b1011, "R4", g0_n, 4'b1011);

    for (int p = 0; p < 32; p++) begin
      for (int c = 0; c < 6; c++) begin
        {br_req_n, req_n} = ~5'(p);
        frame_n = (c != 2); irdy_n = 1'b1;
        @(negedge clk);
        check_all();
      end
    end

    for (int n = 0; n < 4000; n++) begin
      step();
      if (lfsr[3:0] < 4'd5) {br_req_n, req_n} = lfsr[8:4];
      frame_n = lfsr[9] | lfsr[11];
      irdy_n  = lfsr[12] & lfsr[14];
      @(negedge clk);
      check_all();
    end

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule